// File: doc/BRIEF.md
# Eight-Function ALU with Carry-In

This block is a purely combinational arithmetic/logic unit for an 8-bit datapath. It takes two operands, `a_in` and `b_in`, a 3-bit operation selector and a carry-in bit. It returns an 8-bit result and a carry-out bit in the same cycle. The selector chooses from eight operations: two bitwise logic functions, a complement of B, an add with carry, a pass-through of either operand, a negation of A, and a reverse subtraction (B minus A).

All values are 8-bit two's complement. The three arithmetic operations share one adder. The carry-out reports the ninth sum bit for the add. For negation and subtraction it reports "no borrow". For the five non-arithmetic operations it is held low. The surrounding datapath registers the result when it needs to. The block itself has no state, no clock and no reset.

Top module: `alu8_core`

## Requirements
- R1: Selector 3'b000 gives `result = a_in ^ b_in`.
- R2: Selector 3'b001 gives `result = a_in | b_in`.
- R3: Selector 3'b010 gives `result = ~b_in`.
- R4: Selector 3'b011 gives `{carry_out, result} = a_in + b_in + carry_in`, computed 9 bits wide.
- R5: Selector 3'b100 gives `result = a_in`.
- R6: Selector 3'b101 gives `result = b_in`.
- R7: Selector 3'b110 gives `result = (0 - a_in) mod 256`. `carry_out` is 1 exactly when `a_in` is zero.
- R8: Selector 3'b111 gives `result = (b_in - a_in) mod 256`. `carry_out` is 1 exactly when `b_in >= a_in` as unsigned numbers.
- R9: For selectors 3'b000, 3'b001, 3'b010, 3'b100 and 3'b101, `carry_out` is 0.
- R10: For every selector except 3'b011, `result` and `carry_out` do not depend on `carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 8 | Operand A |
| b_in | input | 8 | Operand B |
| op_sel | input | 3 | Operation selector (encoding in R1 to R8) |
| carry_in | input | 1 | Carry into the add operation |
| result | output | 8 | Operation result |
| carry_out | output | 1 | Sum carry or no-borrow flag; 0 for non-arithmetic operations |

## Verification
Every result and carry is due in the same cycle as its stimulus, because no register lies between the inputs and the outputs. The bench applies a new input set just after each rising clock edge. It compares both outputs with a behavioural model at the following falling edge, half a period later, when the combinational path has settled.

Each selector is exercised with corner operands (zero, one, the sign boundaries, all-ones and alternating patterns) under both carry-in values. Pseudo-random operands follow, so that the carry-in independence of R10 is checked on every non-add operation.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [2:0] {
    OP_XOR   = 3'b000,
    OP_OR    = 3'b001,
    OP_NOTB  = 3'b010,
    OP_ADC   = 3'b011,
    OP_PASSA = 3'b100,
    OP_PASSB = 3'b101,
    OP_NEGA  = 3'b110,
    OP_BSUBA = 3'b111
  } alu_op_e;

  function automatic logic op_is_arith(alu_op_e op);
    return (op == OP_ADC) || (op == OP_NEGA) || (op == OP_BSUBA);
  endfunction

endpackage

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);

  always_comb begin
    unique case (op)
      OP_XOR:   y = a ^ b;
      OP_OR:    y = a | b;
      OP_NOTB:  y = ~b;
      OP_PASSA: y = a;
      OP_PASSB: y = b;
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   sum,
  output logic           cout
);

  localparam int SW = W + 1;

  logic [W-1:0] opx;
  logic [W-1:0] opy;
  logic         c0;
  logic [SW-1:0] total;

  // Operand steering: one adder serves add, negate and reverse subtract.
  always_comb begin
    unique case (op)
      OP_NEGA:  begin opx = ~a; opy = '0; c0 = 1'b1; end
      OP_BSUBA: begin opx = ~a; opy = b;  c0 = 1'b1; end
      default:  begin opx = a;  opy = b;  c0 = cin;  end
    endcase
  end

  assign total = {1'b0, opx} + {1'b0, opy} + {{W{1'b0}}, c0};
  assign sum   = total[W-1:0];
  assign cout  = total[W];

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [2:0]   op_sel,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         carry_out
);

  alu_op_e      op;
  logic [W-1:0] logic_y;
  logic [W-1:0] arith_y;
  logic         arith_c;
  logic         arith_sel;

  assign op        = alu_op_e'(op_sel);
  assign arith_sel = op_is_arith(op);

  alu8_logic #(.W(W)) u_logic (
    .op (op),
    .a  (a_in),
    .b  (b_in),
    .y  (logic_y)
  );

  alu8_arith #(.W(W)) u_arith (
    .op   (op),
    .a    (a_in),
    .b    (b_in),
    .cin  (carry_in),
    .sum  (arith_y),
    .cout (arith_c)
  );

  assign result    = arith_sel ? arith_y : logic_y;
  assign carry_out = arith_sel & arith_c;

  always_comb begin
    // R4
    if (op == OP_ADC)
      add_sum_chk: assert ({carry_out, result} ==
                           ({1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, carry_in}))
        else $error("add result mismatch");
    // R7
    if (op == OP_NEGA)
      neg_zero_chk: assert ((result + a_in) == '0 && carry_out == (a_in == '0))
        else $error("negate mismatch");
    // R8
    if (op == OP_BSUBA)
      sub_borrow_chk: assert (carry_out == (b_in >= a_in) && (result + a_in) == b_in)
        else $error("subtract mismatch");
    // R9
    if (!(op == OP_ADC || op == OP_NEGA || op == OP_BSUBA))
      no_carry_chk: assert (carry_out == 1'b0)
        else $error("carry out on non-arithmetic op");
    // R6
    if (op == OP_PASSB)
      pass_b_chk: assert (result == b_in)
        else $error("pass B mismatch");
  end

endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;

  logic       clk;
  logic       rst_n;
  logic [7:0] a_in;
  logic [7:0] b_in;
  logic [2:0] op_sel;
  logic       carry_in;
  logic [7:0] result;
  logic       carry_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  alu8_core uut (
    .a_in      (a_in),
    .b_in      (b_in),
    .op_sel    (op_sel),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic string req_of(int f);
    case (f)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (op=%0d a=%0d b=%0d cin=%0d)",
               tag, act, exp, op_sel, a_in, b_in, carry_in);
    end
  endtask

  // Behavioural reference model.
  task automatic apply(int f, int a, int b, int c);
    int exp_r, exp_c, s;
    string t;
    @(posedge clk);
    #0.5;
    op_sel = f[2:0]; a_in = a[7:0]; b_in = b[7:0]; carry_in = c[0];
    exp_c = 0;
    case (f)
      0: exp_r = a ^ b;
      1: exp_r = a | b;
      2: exp_r = (~b) & 255;
      3: begin s = a + b + c; exp_r = s & 255; exp_c = (s > 255) ? 1 : 0; end
      4: exp_r = a;
      5: exp_r = b;
      6: begin exp_r = (256 - a) & 255; exp_c = (a == 0) ? 1 : 0; end
      default: begin exp_r = (b - a) & 255; exp_c = (b >= a) ? 1 : 0; end
    endcase
    @(negedge clk);
    t = req_of(f);
    if (c == 1 && f != 3) t = {t, "/R10"};
    check(t, int'(result), exp_r);
    if (f == 3 || f >= 6) check(t, int'(carry_out), exp_c);
    else check({t, "/R9"}, int'(carry_out), exp_c);
  endtask

  initial begin
    int corners[7] = '{0, 1, 127, 128, 255, 85, 170};
    rst_n = 1'b0;
    a_in = 8'd0; b_in = 8'd0; op_sel = 3'd0; carry_in = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Output with all-zero inputs (XOR of zeros): R1, R9
    check("R1 reset-state result", int'(result), 0);
    check("R9 reset-state carry", int'(carry_out), 0);
    for (int f = 0; f < 8; f++)
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < 7; i++)
          for (int j = 0; j < 7; j++)
            apply(f, corners[i], corners[j], c);
    for (int k = 0; k < 400; k++)
      apply(int'($urandom_range(7)), int'($urandom_range(255)),
            int'($urandom_range(255)), int'($urandom_range(1)));
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule